// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Port Emulator

This block models the digital side of a serial 12-bit successive-approximation converter. It runs in external-clock mode, where the host's serial clock also paces the conversion. The block acts as the slave and is meant as a synthesizable partner for testing host-side serial controllers. It watches an active-low select, the serial clock and the serial data input. It finds the start bit and collects a control byte. When that byte asks for external-clock mode, the block raises a strobe for one serial-clock period. It then shifts a 12-bit code, taken from a parallel input, out on the serial data output.

All three host pins are synchronised into the block's own clock, and serial-clock edges are detected there. The block's clock must therefore run several times faster than the serial clock. The two serial outputs come with output-enable signals, so a pad ring can float them while the port is deselected. The decoded control fields stay on outputs until the next control byte completes.

Top module: `sar_port_emu`

## Requirements
- R1: While the select input is high, both output enables are low, so data and strobe float. Within SYNC_STAGES+1 clock cycles of select going low, both enables are high and the strobe drives 0.
- R2: While selected, the first 1 sampled on a rising serial-clock edge is the start bit, and zeros before it are ignored. The next seven rising-edge samples complete the control byte, most significant bit first.
- R3: In the control byte, bits 6:4 give the channel, bit 3 picks unipolar (1) or bipolar (0), bit 2 picks single-ended (1) or differential (0), and bits 1:0 give the clock mode. These fields appear on outputs once the byte completes and hold until the next byte completes.
- R4: Only mode 11 starts a conversion. Any other mode gives no strobe and keeps the data output at 0, and the port goes back to searching for a start bit.
- R5: In mode 11, the strobe rises on the falling edge that follows the eighth control bit. It falls on the next falling edge, so it is high for exactly one serial-clock period.
- R6: The parallel sample input is captured on the falling edge where the strobe rises. Later changes to it do not affect the result being shifted out.
- R7: On each of the 12 falling edges after the strobe period, the data output presents one result bit, most significant first.
- R8: In unipolar mode the result is the sample input unchanged (straight binary). In bipolar mode the most significant bit of the sample is inverted, which turns the offset-binary code into two's complement.
- R9: The data output is 0 during the control byte and the strobe period, and from the falling edge after the last result bit onward.
- R10: Serial data is ignored from the eighth control bit until the falling edge after the last result bit. From then on, a new start bit begins a new control byte within the same selection.
- R11: Select going high at any point aborts a control byte or a conversion in progress. The next selection starts by searching for a start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Active-low port select from the host |
| sclk_i | input | 1 | Host serial clock |
| sdi_i | input | 1 | Host serial data into the port |
| sample_i | input | RES_W | Code to be returned, in straight binary |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| strb_o | output | 1 | Conversion strobe |
| strb_oe_o | output | 1 | Output enable for strb_o |
| chan_o | output | 3 | Channel field of the last control byte |
| unipolar_o | output | 1 | Unipolar flag of the last control byte |
| single_o | output | 1 | Single-ended flag of the last control byte |
| extclk_o | output | 1 | Last control byte selected external-clock mode |

## Verification
The bench builds the block with its defaults: RES_W of 12 and SYNC_STAGES of 2. Each serial-clock phase lasts six block clocks, which covers the three-cycle path from a pin edge to a registered output. With 12 result bits, one full conversion fits in a 21-clock window. That makes it possible to shift frames by up to four leading zeros and to put two control bytes back to back in one selection. A 12-bit code also gives the bipolar corner values 0x000, 0x7FF and 0x801 a distinct sign bit to flip.

// File: rtl/sar_emu_pkg.sv
package sar_emu_pkg;

  localparam int CTL_W = 8;
  localparam logic [1:0] PM_EXTCLK = 2'b11;

  typedef enum logic [1:0] {
    SQ_HUNT,
    SQ_ARM,
    SQ_STRB,
    SQ_DATA
  } seq_state_e;

  // control fields that follow the start bit, most significant first
  typedef struct packed {
    logic [2:0] chan;
    logic       unipolar;
    logic       single;
    logic [1:0] pmode;
  } ctl_fields_t;

endpackage

// File: rtl/sar_emu_front.sv
module sar_emu_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_raw,
  input  logic sclk_raw,
  input  logic din_raw,
  output logic sel,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic din_s
);

  localparam int NSIG = 3;
  localparam int LAST = SYNC_STAGES - 1;
  // bit order {select, serial clock, data}; select idles high
  localparam logic [NSIG-1:0] IDLE_LVL = 3'b100;

  logic [NSIG-1:0] sync_q [SYNC_STAGES];
  logic            sclk_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= IDLE_LVL;
    end else begin
      sync_q[0] <= {csn_raw, sclk_raw, din_raw};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_last_q <= 1'b0;
    else        sclk_last_q <= sync_q[LAST][1];
  end

  assign sel       = ~sync_q[LAST][2];
  assign din_s     =  sync_q[LAST][0];
  assign sclk_rise =  sync_q[LAST][1] & ~sclk_last_q;
  assign sclk_fall = ~sync_q[LAST][1] &  sclk_last_q;

endmodule

// File: rtl/sar_emu_ctl_rx.sv
module sar_emu_ctl_rx
  import sar_emu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             hunt,
  input  logic             rise,
  input  logic             din,
  output logic             byte_done,
  output logic [CTL_W-2:0] fields
);

  localparam int CNT_W = $clog2(CTL_W + 1);
  localparam int FW    = CTL_W - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FW-1:0]    sr_q, sr_d;
  logic             done_q, done_d;
  logic             rx_en;

  // the start bit itself is not stored: a nonzero count marks it seen
  always_comb begin
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    done_d = 1'b0;
    if (!sel || !hunt) begin
      cnt_d = '0;
    end else if (rise) begin
      if (cnt_q == '0) begin
        if (din) begin
          cnt_d = CNT_W'(1);
          sr_d  = '0;
        end
      end else begin
        sr_d = {sr_q[FW-2:0], din};
        if (cnt_q == CNT_W'(CTL_W - 1)) begin
          cnt_d  = '0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  assign rx_en = !sel || !hunt || rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (rx_en) begin
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign byte_done = done_q;
  assign fields    = sr_q;

endmodule

// File: rtl/sar_emu_seq.sv
module sar_emu_seq
  import sar_emu_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             fall,
  input  logic             byte_done,
  input  logic [CTL_W-2:0] fields,
  output logic             hunt,
  output logic             load,
  output logic             shift,
  output logic             strobe,
  output ctl_fields_t      ctl
);

  localparam int BIT_W = $clog2(RES_W + 1);

  seq_state_e       state_q, state_d;
  logic [BIT_W-1:0] bits_q, bits_d;
  logic             strb_q, strb_d;
  ctl_fields_t      ctl_q, ctl_d;
  ctl_fields_t      rx_ctl;

  assign rx_ctl = ctl_fields_t'(fields);

  always_comb begin
    state_d = state_q;
    bits_d  = bits_q;
    strb_d  = strb_q;
    ctl_d   = ctl_q;
    load    = 1'b0;
    shift   = 1'b0;
    if (!sel) begin
      state_d = SQ_HUNT;
      bits_d  = '0;
      strb_d  = 1'b0;
    end else begin
      case (state_q)
        SQ_HUNT: begin
          if (byte_done) begin
            ctl_d = rx_ctl;
            if (rx_ctl.pmode == PM_EXTCLK) state_d = SQ_ARM;
          end
        end
        SQ_ARM: begin
          if (fall) begin
            state_d = SQ_STRB;
            strb_d  = 1'b1;
            load    = 1'b1;
          end
        end
        SQ_STRB: begin
          if (fall) begin
            state_d = SQ_DATA;
            strb_d  = 1'b0;
            shift   = 1'b1;
            bits_d  = BIT_W'(1);
          end
        end
        SQ_DATA: begin
          if (fall) begin
            shift = 1'b1;
            // the shift after the last result bit presents the padding zero
            if (bits_q == BIT_W'(RES_W)) begin
              state_d = SQ_HUNT;
              bits_d  = '0;
            end else begin
              bits_d = bits_q + 1'b1;
            end
          end
        end
        default: state_d = SQ_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_HUNT;
      bits_q  <= '0;
      strb_q  <= 1'b0;
      ctl_q   <= '0;
    end else begin
      state_q <= state_d;
      bits_q  <= bits_d;
      strb_q  <= strb_d;
      ctl_q   <= ctl_d;
    end
  end

  assign hunt   = (state_q == SQ_HUNT);
  assign strobe = strb_q;
  assign ctl    = ctl_q;

endmodule

// File: rtl/sar_emu_res_tx.sv
module sar_emu_res_tx #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             load,
  input  logic             shift,
  input  logic             unipolar,
  input  logic [RES_W-1:0] sample,
  output logic             dout
);

  logic [RES_W-1:0] sr_q, sr_d;
  logic [RES_W-1:0] code;
  logic             dout_q, dout_d;
  logic             tx_en;

  // bipolar: flipping the sign bit maps offset binary onto two's complement
  assign code = unipolar ? sample : {~sample[RES_W-1], sample[RES_W-2:0]};

  always_comb begin
    sr_d   = sr_q;
    dout_d = dout_q;
    if (!sel) begin
      sr_d   = '0;
      dout_d = 1'b0;
    end else if (load) begin
      sr_d   = code;
      dout_d = 1'b0;
    end else if (shift) begin
      dout_d = sr_q[RES_W-1];
      sr_d   = {sr_q[RES_W-2:0], 1'b0};
    end
  end

  assign tx_en = !sel || load || shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      dout_q <= 1'b0;
    end else if (tx_en) begin
      sr_q   <= sr_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/sar_port_emu.sv
module sar_port_emu
  import sar_emu_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csn_i,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             strb_o,
  output logic             strb_oe_o,
  output logic [2:0]       chan_o,
  output logic             unipolar_o,
  output logic             single_o,
  output logic             extclk_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_core_n;
  logic             sel, sclk_rise, sclk_fall, din_s;
  logic             hunt, byte_done, load, shift, strobe;
  logic [CTL_W-2:0] fields;
  ctl_fields_t      ctl;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  sar_emu_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .csn_raw  (csn_i),
    .sclk_raw (sclk_i),
    .din_raw  (sdi_i),
    .sel      (sel),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .din_s    (din_s)
  );

  sar_emu_ctl_rx i_rx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sel      (sel),
    .hunt     (hunt),
    .rise     (sclk_rise),
    .din      (din_s),
    .byte_done(byte_done),
    .fields   (fields)
  );

  sar_emu_seq #(.RES_W(RES_W)) i_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sel      (sel),
    .fall     (sclk_fall),
    .byte_done(byte_done),
    .fields   (fields),
    .hunt     (hunt),
    .load     (load),
    .shift    (shift),
    .strobe   (strobe),
    .ctl      (ctl)
  );

  sar_emu_res_tx #(.RES_W(RES_W)) i_tx (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .sel     (sel),
    .load    (load),
    .shift   (shift),
    .unipolar(ctl.unipolar),
    .sample  (sample_i),
    .dout    (sdo_o)
  );

  assign strb_o     = strobe;
  assign sdo_oe_o   = sel;
  assign strb_oe_o  = sel;
  assign chan_o     = ctl.chan;
  assign unipolar_o = ctl.unipolar;
  assign single_o   = ctl.single;
  assign extclk_o   = (ctl.pmode == PM_EXTCLK);

endmodule

// File: rtl/sar_port_emu_chk.sv
module sar_port_emu_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic csn_i,
  input logic sel,
  input logic sclk_fall,
  input logic hunt,
  input logic byte_done,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic strb_o,
  input logic strb_oe_o
);

  localparam int DW = $clog2(SYNC_STAGES + 3);

  logic [DW-1:0] desel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             desel_q <= '0;
    else if (!csn_i)                        desel_q <= '0;
    else if (desel_q != DW'(SYNC_STAGES + 2)) desel_q <= desel_q + 1'b1;
  end

  a_r1_float_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (desel_q == DW'(SYNC_STAGES + 2)) |-> (!sdo_oe_o && !strb_oe_o));

  a_r1_strobe_low_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_oe_o) |-> !strb_o);

  a_r5_strobe_rises_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_o) |-> ($past(sclk_fall) && $past(sel)));

  a_r5_strobe_drops_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb_o) |-> ($past(sclk_fall) || !$past(sel)));

  a_r9_dout_quiet_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strb_o |-> !sdo_o);

  a_r7_dout_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> ($past(sclk_fall) || !$past(sel)));

  a_r10_no_byte_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(hunt));

endmodule

bind sar_port_emu sar_port_emu_chk #(.SYNC_STAGES(SYNC_STAGES)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .csn_i    (csn_i),
  .sel      (sel),
  .sclk_fall(sclk_fall),
  .hunt     (hunt),
  .byte_done(byte_done),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o),
  .strb_o   (strb_o),
  .strb_oe_o(strb_oe_o)
);

// File: tb/test_sar_port_emu.sv
module test_sar_port_emu;

  localparam int RES_W = 12;
  localparam int H     = 6;
  localparam int NV    = 8;
  // {ctl[25:18], sample[17:6], lead[5:2], fill[1], change[0]}
  localparam logic [25:0] VEC [NV] = '{
    {8'h8F, 12'hABC, 4'd0, 1'b0, 1'b0},
    {8'hD7, 12'h123, 4'd2, 1'b1, 1'b0},
    {8'hFB, 12'hFFF, 4'd1, 1'b0, 1'b1},
    {8'hA3, 12'h000, 4'd3, 1'b1, 1'b1},
    {8'h8F, 12'h801, 4'd0, 1'b1, 1'b0},
    {8'hBD, 12'h555, 4'd0, 1'b0, 1'b0},
    {8'hC0, 12'h2AA, 4'd4, 1'b0, 1'b0},
    {8'h97, 12'h7FF, 4'd0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [RES_W-1:0] smp = '0;
  logic sdo, sdo_oe, strb, strb_oe, uni, sgl, ext;
  logic [2:0] chan;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] act_d, act_s;
  bit oe_drop;

  always #10 clk = ~clk;

  sar_port_emu #(.RES_W(RES_W), .SYNC_STAGES(2)) i_sar_port_emu (
    .clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .sample_i(smp), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .strb_o(strb),
    .strb_oe_o(strb_oe), .chan_o(chan), .unipolar_o(uni), .single_o(sgl),
    .extclk_o(ext)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit k of a stream sits at index 63-k; capture follows each falling edge
  task automatic clock_bits(input logic [63:0] bits, input int n, input int chg_at);
    act_d = '0; act_s = '0; oe_drop = 1'b0;
    for (int k = 0; k < n; k++) begin
      sdi = bits[63-k];
      tick(H); sclk = 1'b1;
      tick(H); sclk = 1'b0;
      tick(H);
      act_d[63-k] = sdo;
      act_s[63-k] = strb;
      if (!sdo_oe || !strb_oe) oe_drop = 1'b1;
      if (k == chg_at) smp = ~smp;
    end
    sdi = 1'b0;
  endtask

  function automatic logic [63:0] put_ctl(input logic [63:0] b, input logic [7:0] c, input int off);
    for (int i = 0; i < 8; i++) b[63-off-i] = c[7-i];
    return b;
  endfunction

  task automatic add_exp(input logic [7:0] c, input logic [RES_W-1:0] s, input int off,
                         inout logic [63:0] ed, inout logic [63:0] es);
    logic [RES_W-1:0] w;
    if (c[1:0] == 2'b11) begin
      w = c[3] ? s : {~s[RES_W-1], s[RES_W-2:0]};
      es[63-(off+7)] = 1'b1;
      for (int i = 0; i < RES_W; i++) ed[63-(off+8+i)] = w[RES_W-1-i];
    end
  endtask

  task automatic select_on();
    csn = 1'b0;
    tick(4);
    check(sdo_oe && strb_oe && !strb, "R1 enables on select, strobe low",
          {sdo_oe, strb_oe, strb}, 64'b110);
  endtask

  task automatic select_off();
    csn = 1'b1;
    tick(4);
    check(!sdo_oe && !strb_oe, "R1 float on deselect", {sdo_oe, strb_oe}, 64'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog (whole run): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] bits, ed, es;
    logic [7:0] c;
    logic [RES_W-1:0] s;
    int ld;
    bit fl, cg;

    // reset state
    tick(3);
    check(!sdo_oe && !strb_oe && !strb && !sdo, "R1 reset outputs",
          {sdo_oe, strb_oe, strb, sdo}, 64'b0);
    rst_n = 1'b1;
    tick(5);
    check({chan, uni, sgl, ext} == 6'b0, "R3 reset decode", {chan, uni, sgl, ext}, 64'b0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      c  = VEC[v][25:18];
      s  = VEC[v][17:6];
      ld = int'(VEC[v][5:2]);
      fl = VEC[v][1];
      cg = VEC[v][0];
      bits = put_ctl(64'b0, c, ld);
      if (fl) for (int k = ld + 8; k <= ld + 20; k++) bits[63-k] = 1'b1;
      ed = '0; es = '0;
      add_exp(c, s, ld, ed, es);
      smp = s;
      select_on();
      clock_bits(bits, 32, cg ? ld + 7 : -1);
      check(act_s == es, "R5 R4 R2 strobe stream", act_s, es);
      if (cg)      check(act_d == ed, "R6 late sample change ignored", act_d, ed);
      else if (fl) check(act_d == ed, "R10 din ignored during conversion", act_d, ed);
      else         check(act_d == ed, "R7 R8 R9 data stream", act_d, ed);
      check(!oe_drop, "R1 enables held while selected", {63'b0, oe_drop}, 64'b0);
      check({chan, uni, sgl, ext} == {c[6:4], c[3], c[2], c[1:0] == 2'b11},
            "R3 decoded fields", {chan, uni, sgl, ext}, {c[6:4], c[3], c[2], c[1:0] == 2'b11});
      select_off();
    end

    // abort in the middle of the result
    smp = 12'h0A5;
    select_on();
    clock_bits(put_ctl(64'b0, 8'h8F, 0), 14, -1);
    csn = 1'b1;
    tick(3);
    check(!sdo_oe && !strb_oe, "R1 float right after abort", {sdo_oe, strb_oe}, 64'b0);
    tick(3);
    smp = 12'h3C5;
    select_on();
    clock_bits(put_ctl(64'b0, 8'h8F, 0), 32, -1);
    ed = '0; es = '0;
    add_exp(8'h8F, 12'h3C5, 0, ed, es);
    check(act_d == ed && act_s == es, "R11 restart after data abort", act_d, ed);
    select_off();

    // abort in the middle of a control byte
    select_on();
    clock_bits({4'b1101, 60'b0}, 4, -1);
    select_off();
    smp = 12'h456;
    select_on();
    clock_bits(put_ctl(64'b0, 8'h97, 1), 32, -1);
    ed = '0; es = '0;
    add_exp(8'h97, 12'h456, 1, ed, es);
    check(act_d == ed && act_s == es, "R11 R2 restart after control abort", act_d, ed);
    select_off();

    // non-external byte followed by an external one in one selection
    smp = 12'h0F0;
    select_on();
    clock_bits(put_ctl(put_ctl(64'b0, 8'hBD, 0), 8'h8F, 12), 36, -1);
    ed = '0; es = '0;
    add_exp(8'h8F, 12'h0F0, 12, ed, es);
    check(act_d == ed && act_s == es, "R4 search resumes after other mode", act_d, ed);
    select_off();

    // two conversions back to back in one selection
    smp = 12'h6E1;
    select_on();
    clock_bits(put_ctl(put_ctl(64'b0, 8'h8F, 0), 8'hD7, 21), 44, -1);
    ed = '0; es = '0;
    add_exp(8'h8F, 12'h6E1, 0, ed, es);
    add_exp(8'hD7, 12'h6E1, 21, ed, es);
    check(act_s == es, "R10 second strobe after padding edge", act_s, es);
    check(act_d == ed, "R10 second result stream", act_d, ed);
    check({chan, uni, sgl, ext} == {3'b101, 1'b0, 1'b1, 1'b1}, "R3 fields follow latest byte",
          {chan, uni, sgl, ext}, {3'b101, 1'b0, 1'b1, 1'b1});
    select_off();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule